// File: doc/BRIEF.md
# Multi-Polynomial Reflected CRC Engine

This block keeps a running cyclic redundancy checksum over a stream of data beats. It offers three standard generator polynomials: two of 32 bits and one of 16 bits. Every beat is folded in starting with its least significant bit, so the engine works in the reflected form of each polynomial. A fetch unit or another producer feeds it one beat per clock. Each beat is a byte, a halfword or a word, and only the bits of that size are folded in.

A computation begins with an initialise pulse. The pulse loads the seed that suits the chosen polynomial and captures the polynomial and width selects. Those captured selects hold until the next initialise pulse. The accumulator is visible on the output in every cycle, so the partial checksum can be read while a stream is still in progress. The engine applies no final inversion. Any output conditioning is left to the user.

Top module: `crc_engine`

## Requirements
- R1: After reset, and before any initialise pulse, `crc_o` is 0 and `ready_o` is 0.
- R2: The cycle after `init_i` is high, `ready_o` is 1 and `crc_o` holds the seed: 0x0000FFFF when `poly_i` was 2, otherwise 0xFFFFFFFF.
- R3: The `poly_i` encoding uses reflected constants: 0 selects 0xEDB88320, 1 selects 0x82F63B78, 2 selects the 16-bit 0x8408, and 3 behaves as 0.
- R4: Bits are folded least significant first. After the seed, the ASCII bytes "123456789" give 0x340BC6D9 for poly 0, 0x1CF96D7C for poly 1 and 0x00006F91 for poly 2.
- R5: The `width_i` encoding sets the beat size: 0 folds `data_i[7:0]`, 1 folds `data_i[15:0]`, and 2 or 3 fold all 32 bits. Bits above the beat size have no effect.
- R6: While `ready_o` is 1, a beat with `valid_i` high is absorbed at that clock edge, one beat per cycle with no gaps.
- R7: A beat is ignored while `ready_o` is 0. A beat presented in the same cycle as `init_i` is also dropped, because the initialise pulse wins.
- R8: A change on `poly_i` or `width_i` between initialise pulses has no effect on the checksum.
- R9: With polynomial 2 active, `crc_o[31:16]` is always 0.
- R10: No final XOR is applied. `crc_o` shows the raw accumulator and holds its value in cycles with neither `valid_i` nor `init_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Loads the seed and captures the selects |
| valid_i | input | 1 | A data beat is present |
| data_i | input | 32 | Data beat, LSB aligned |
| width_i | input | 2 | Beat size select |
| poly_i | input | 2 | Polynomial select |
| crc_o | output | 32 | Running accumulator value |
| ready_o | output | 1 | Engine is initialised and accepts beats |

## Verification
The byte stream "123456789" is run under each polynomial against fixed known answers. This separates a wrong constant, a wrong seed and the wrong bit order, since a most-significant-first fold gives entirely different values. Multi-beat streams in halfword and word mode are compared with a bit-serial model in the bench. Those streams use the reserved codes, polynomial 3 and width 3. Together they show whether the unrolled depth follows the latched width and whether the reserved codes alias as required. Directed sequences cover the remaining cases:
- Junk placed in the upper data bits.
- Select changes in the middle of a stream.
- A beat that coincides with initialise.
- Beats sent before any initialise.
- Idle gaps in a stream.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned CRC_W  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_BW = 3;

  typedef enum logic [1:0] {
    POLY_ETH  = 2'd0,
    POLY_CAST = 2'd1,
    POLY_C16  = 2'd2,
    POLY_RSV  = 2'd3
  } poly_e;

  typedef enum logic [1:0] {
    BEAT_B8  = 2'd0,
    BEAT_H16 = 2'd1,
    BEAT_W32 = 2'd2,
    BEAT_RSV = 2'd3
  } beat_e;

  function automatic logic [CRC_W-1:0] poly_coef(poly_e p);
    case (p)
      POLY_CAST: poly_coef = 32'h82F6_3B78;
      POLY_C16:  poly_coef = 32'h0000_8408;
      default:   poly_coef = 32'hEDB8_8320;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] poly_seed(poly_e p);
    poly_seed = (p == POLY_C16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/crc_cfg.sv
module crc_cfg
  import crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  init_i,
  input  poly_e poly_i,
  input  beat_e width_i,
  output logic  active_o,
  output poly_e poly_o,
  output beat_e width_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      poly_o   <= POLY_ETH;
      width_o  <= BEAT_B8;
    end else if (init_i) begin
      active_o <= 1'b1;
      poly_o   <= poly_i;
      width_o  <= width_i;
    end
  end

  // R8: selects frozen between initialise pulses
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !init_i) |=> ($stable(poly_o) && $stable(width_o)));

endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  input  poly_e         poly_i,
  input  beat_e         width_i,
  output logic [CW-1:0] crc_o
);

  logic [CW-1:0] coef;
  logic [CW-1:0] res [NUM_BW];

  assign coef = poly_coef(poly_i);

  // one unrolled LSB-first fold per beat size
  for (genvar g = 0; g < NUM_BW; g++) begin : g_bw
    localparam int unsigned NB = 8 << g;
    always_comb begin
      logic [CW-1:0] c;
      c = crc_i;
      for (int b = 0; b < NB; b++) begin
        c = (c >> 1) ^ ({CW{c[0] ^ data_i[b]}} & coef);
      end
      res[g] = c;
    end
  end

  always_comb begin
    case (width_i)
      BEAT_B8:  crc_o = res[0];
      BEAT_H16: crc_o = res[1];
      default:  crc_o = res[2];
    endcase
  end

endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import crc_pkg::*;
#(
  parameter int unsigned CW = CRC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          load_i,
  input  poly_e         seed_poly_i,
  input  poly_e         act_poly_i,
  input  logic          active_i,
  input  logic [CW-1:0] next_i,
  output logic [CW-1:0] crc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '0;
    else if (init_i)  crc_o <= poly_seed(seed_poly_i);
    else if (load_i)  crc_o <= next_i;
  end

  // R9: 16-bit polynomial never sets the upper half
  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && act_poly_i == POLY_C16) |-> (crc_o[CW-1:16] == '0));

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        poly_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              ready_o
);

  poly_e             poly_q;
  beat_e             width_q;
  logic              active_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_nxt;
  logic              take;

  crc_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (init_i),
    .poly_i   (poly_e'(poly_i)),
    .width_i  (beat_e'(width_i)),
    .active_o (active_q),
    .poly_o   (poly_q),
    .width_o  (width_q)
  );

  crc_fold #(.CW(CRC_W), .DW(DATA_W)) u_fold (
    .crc_i   (crc_q),
    .data_i  (data_i),
    .poly_i  (poly_q),
    .width_i (width_q),
    .crc_o   (crc_nxt)
  );

  // init wins over a coincident beat
  assign take = valid_i && active_q && !init_i;

  crc_acc #(.CW(CRC_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .load_i      (take),
    .seed_poly_i (poly_e'(poly_i)),
    .act_poly_i  (poly_q),
    .active_i    (active_q),
    .next_i      (crc_nxt),
    .crc_o       (crc_q)
  );

  assign crc_o   = crc_q;
  assign ready_o = active_q;

  // R2: seed follows the select seen with the pulse
  a_r2_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (ready_o && crc_o == (($past(poly_i) == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF)));

  // R7: nothing moves before the first initialise
  a_r7_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !init_i) |=> $stable(crc_o));

  // R10: accumulator holds without a beat
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !valid_i) |=> $stable(crc_o));

  // R1: ready never drops once raised
  a_r1_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [1:0]  width_i = '0;
  logic [1:0]  poly_i = '0;
  logic [31:0] crc_o;
  logic        ready_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crc_engine u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .width_i (width_i),
    .poly_i  (poly_i),
    .crc_o   (crc_o),
    .ready_o (ready_o)
  );

  // known answers: poly, byte stream "123456789", raw result
  localparam logic [33:0] KAT [3] = '{
    {2'd0, 32'h340B_C6D9},
    {2'd1, 32'h1CF9_6D7C},
    {2'd2, 32'h0000_6F91}
  };

  // model rows: poly, width, three beats
  localparam logic [99:0] MROW [6] = '{
    {2'd0, 2'd1, 32'h0000_A55A, 32'h0000_1234, 32'h0000_FFFF},
    {2'd1, 2'd2, 32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0001},
    {2'd2, 2'd2, 32'hCAFE_F00D, 32'h0000_0000, 32'hFFFF_FFFF},
    {2'd2, 2'd1, 32'h0000_3132, 32'h0000_3334, 32'h0000_0001},
    {2'd3, 2'd3, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_F0F0},
    {2'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 32'h0000_00FE}
  };

  function automatic logic [31:0] ref_fold(logic [31:0] c, logic [31:0] d,
                                           logic [1:0] p, logic [1:0] w);
    logic [31:0] k;
    int nb;
    k  = (p == 2'd1) ? 32'h82F6_3B78 : (p == 2'd2) ? 32'h0000_8408 : 32'hEDB8_8320;
    nb = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    for (int i = 0; i < nb; i++) begin
      if ((c[0] ^ d[i]) == 1'b1) c = (c >> 1) ^ k;
      else                        c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_seed(logic [1:0] p);
    return (p == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic ini, logic vld, logic [31:0] d);
    @(negedge clk_i);
    init_i  = ini;
    valid_i = vld;
    data_i  = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    logic [31:0] held;

    repeat (3) @(negedge clk_i);
    check("R1 crc", crc_o, 32'h0);
    check("R1 ready", {31'h0, ready_o}, 32'h0);
    rst_ni = 1'b1;

    // R7: beats before any init are ignored
    cyc(1'b0, 1'b1, 32'h1234_5678);
    cyc(1'b0, 1'b1, 32'h9ABC_DEF0);
    cyc(1'b0, 1'b0, 32'h0);
    check("R7 pre-init crc", crc_o, 32'h0);
    check("R7 pre-init ready", {31'h0, ready_o}, 32'h0);

    // R3 R4: known-answer table walked by one loop
    for (int r = 0; r < 3; r++) begin
      poly_i  = KAT[r][33:32];
      width_i = 2'd0;
      cyc(1'b1, 1'b0, 32'h0);
      cyc(1'b0, 1'b0, 32'h0);
      check("R2 seed", crc_o, ref_seed(KAT[r][33:32]));
      check("R2 ready", {31'h0, ready_o}, 32'h1);
      for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 32'h31 + i);
      cyc(1'b0, 1'b0, 32'h0);
      check("R4 kat", crc_o, KAT[r][31:0]);
    end

    // R5 R6: multi-width rows against the model, back to back beats
    for (int r = 0; r < 6; r++) begin
      poly_i  = MROW[r][99:98];
      width_i = MROW[r][97:96];
      cyc(1'b1, 1'b0, 32'h0);
      exp = ref_seed(MROW[r][99:98]);
      for (int i = 0; i < 3; i++) begin
        cyc(1'b0, 1'b1, MROW[r][95 - 32*i -: 32]);
        exp = ref_fold(exp, MROW[r][95 - 32*i -: 32], MROW[r][99:98], MROW[r][97:96]);
      end
      cyc(1'b0, 1'b0, 32'h0);
      check("R6 R5 R3 model row", crc_o, exp);
    end

    // R5: bits above the byte are ignored
    poly_i = 2'd0; width_i = 2'd0;
    cyc(1'b1, 1'b0, 32'h0);
    cyc(1'b0, 1'b1, 32'hABCD_EF31);
    cyc(1'b0, 1'b0, 32'h0);
    check("R5 upper ignored", crc_o, ref_fold(32'hFFFF_FFFF, 32'h31, 2'd0, 2'd0));

    // R8: select change mid-stream has no effect
    poly_i = 2'd1; width_i = 2'd1;
    cyc(1'b1, 1'b0, 32'h0);
    exp = ref_fold(32'hFFFF_FFFF, 32'h0000_5AA5, 2'd1, 2'd1);
    cyc(1'b0, 1'b1, 32'h0000_5AA5);
    poly_i = 2'd2; width_i = 2'd2;
    cyc(1'b0, 1'b1, 32'h7777_C3C3);
    exp = ref_fold(exp, 32'h0000_C3C3, 2'd1, 2'd1);
    cyc(1'b0, 1'b0, 32'h0);
    check("R8 frozen selects", crc_o, exp);

    // R10: value holds over idle cycles
    held = crc_o;
    cyc(1'b0, 1'b0, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 32'h1);
    check("R10 hold", crc_o, held);

    // R7: init with a coincident beat drops the beat
    poly_i = 2'd2; width_i = 2'd2;
    cyc(1'b1, 1'b1, 32'h1234_5678);
    cyc(1'b0, 1'b0, 32'h0);
    check("R7 init wins", crc_o, 32'h0000_FFFF);

    // R9: 16-bit polynomial keeps upper half clear over word beats
    exp = 32'h0000_FFFF;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1'b1, 32'hF0E1_D2C3 ^ (32'h1111_1111 * i));
      exp = ref_fold(exp, 32'hF0E1_D2C3 ^ (32'h1111_1111 * i), 2'd2, 2'd2);
    end
    cyc(1'b0, 1'b0, 32'h0);
    check("R9 upper zero", {crc_o[31:16], 16'h0}, 32'h0);
    check("R9 value", crc_o, exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule